// File: doc/BRIEF.md
# Sample Window Watchdog

This block sits on the result stream of a converter sequencer. It checks each valid sample against a programmable window with an upper and a lower bound. When a checked sample leaves the window, it raises a sticky status flag. Software clears the flag by writing one to it. An interrupt output follows the flag when its own enable is set.

The comparison is made on the raw converter value, before any left or right alignment. The bounds are therefore given in that same unaligned, right-justified form. When the converter runs at reduced resolution, the sample is treated as zero-padded at its most significant end. The watchdog can check every channel, or only the samples of one programmed channel.

A single configuration write strobe loads all the control fields at once. A sample presented in the same cycle as that write is still judged by the previous settings.

Top module: `win_watchdog`

## Requirements
- R1: After reset the flag and the interrupt are low and the watchdog is disabled, so no sample sets the flag until a configuration write sets the enable.
- R2: An enabled, checked sample sets the flag one cycle after it is presented if its value is strictly greater than the upper bound or strictly less than the lower bound. A value equal to either bound is inside the window.
- R3: With the single-channel bit set, only samples whose channel number equals the programmed channel are checked. Samples from other channels never set the flag.
- R4: With the single-channel bit clear, samples from every channel are checked.
- R5: Once set, the flag stays set through later in-window samples and through disabling the watchdog, until it is cleared.
- R6: A status write with the clear bit at 1 clears the flag on the next edge. A status write with the clear bit at 0 leaves the flag unchanged.
- R7: When a sample that sets the flag and a clearing status write fall in the same cycle, the flag ends up set.
- R8: The interrupt output is high exactly while the flag is high and the interrupt enable is set.
- R9: The resolution input selects the effective sample width, which is SAMPLE_W minus 2 times the code (code 0 is full width). Sample bits above that width are ignored, so the value is compared as if zero-padded at the top.
- R10: A configuration write takes effect for samples presented from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Raw, unaligned sample value |
| smp_chan | input | CH_W | Channel number of the sample |
| smp_res | input | 2 | Resolution code of the sample |
| cfg_wr | input | 1 | Loads all configuration fields below |
| cfg_en | input | 1 | Watchdog enable |
| cfg_single | input | 1 | Check only the programmed channel |
| cfg_chan | input | CH_W | Programmed channel |
| cfg_hi | input | SAMPLE_W | Upper bound of the window |
| cfg_lo | input | SAMPLE_W | Lower bound of the window |
| cfg_irq_en | input | 1 | Interrupt enable |
| stat_wr | input | 1 | Status write strobe |
| stat_clr | input | 1 | Status write data; 1 clears the flag |
| flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with SAMPLE_W=8 and CH_W=2. At that size every sample value can be swept against several windows under all four resolution codes. That reaches both bounds and each value just beyond them, and also the masking of the top bits. The narrow channel field lets the single-channel filter be tried against every channel number. The bench also drives same-cycle set and clear, a status write with data 0, a configuration write that coincides with a sample, and the interrupt under both enable settings.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int SAMPLE_W = 12,
  parameter int CH_W     = 5,
  parameter int RES_STEP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [CH_W-1:0]     smp_chan,
  input  logic [1:0]          smp_res,
  input  logic                cfg_wr,
  input  logic                cfg_en,
  input  logic                cfg_single,
  input  logic [CH_W-1:0]     cfg_chan,
  input  logic [SAMPLE_W-1:0] cfg_hi,
  input  logic [SAMPLE_W-1:0] cfg_lo,
  input  logic                cfg_irq_en,
  input  logic                stat_wr,
  input  logic                stat_clr,
  output logic                flag,
  output logic                irq
);
  localparam logic [SAMPLE_W-1:0] FULL = {SAMPLE_W{1'b1}};

  logic                en_q, single_q, ie_q;
  logic [CH_W-1:0]     chan_q;
  logic [SAMPLE_W-1:0] hi_q, lo_q;
  logic [SAMPLE_W-1:0] eff;
  logic                ch_ok, outside, hit, clr;

  assign eff     = smp_data & (FULL >> (RES_STEP * int'(smp_res)));
  assign ch_ok   = !single_q || (smp_chan == chan_q);
  assign outside = (eff > hi_q) || (eff < lo_q);
  assign hit     = smp_valid && en_q && ch_ok && outside;
  assign clr     = stat_wr && stat_clr;
  assign irq     = flag && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      single_q <= 1'b0;
      ie_q     <= 1'b0;
      chan_q   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (cfg_wr) begin
      en_q     <= cfg_en;
      single_q <= cfg_single;
      ie_q     <= cfg_irq_en;
      chan_q   <= cfg_chan;
      hi_q     <= cfg_hi;
      lo_q     <= cfg_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R2 R7
  set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && en_q && ch_ok && (eff > hi_q || eff < lo_q)) |=> flag);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(stat_wr && stat_clr)) |=> flag);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_clr && !smp_valid) |=> !flag);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !flag) |=> !flag);

  // R3
  other_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_q && smp_chan != chan_q && !flag) |=> !flag);

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int CW = 2;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic [SW-1:0] smp_data = '0;
  logic [CW-1:0] smp_chan = '0;
  logic [1:0] smp_res = '0;
  logic cfg_wr = 0, cfg_en = 0, cfg_single = 0, cfg_irq_en = 0;
  logic [CW-1:0] cfg_chan = '0;
  logic [SW-1:0] cfg_hi = '0, cfg_lo = '0;
  logic stat_wr = 0, stat_clr = 0;
  logic flag, irq;

  int checks = 0, failures = 0;
  int m_en = 0, m_single = 0, m_chan = 0, m_hi = 0, m_lo = 0, m_ie = 0;
  bit done = 0;

  win_watchdog #(.SAMPLE_W(SW), .CH_W(CW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int en, input int single, input int ch,
                           input int hi, input int lo, input int ie);
    @(negedge clk);
    cfg_wr = 1; cfg_en = en[0]; cfg_single = single[0]; cfg_chan = ch[CW-1:0];
    cfg_hi = hi[SW-1:0]; cfg_lo = lo[SW-1:0]; cfg_irq_en = ie[0];
    m_en = en; m_single = single; m_chan = ch; m_hi = hi; m_lo = lo; m_ie = ie;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic clear_flag();
    stat_wr = 1; stat_clr = 1;
    @(negedge clk);
    stat_wr = 0; stat_clr = 0;
  endtask

  function automatic int expect_hit(input int d, input int ch, input int res);
    int w = SW - 2*res;
    int v = d % (1 << w);
    if (m_en == 0) return 0;
    if (m_single != 0 && ch != m_chan) return 0;
    return (v > m_hi || v < m_lo) ? 1 : 0;
  endfunction

  task automatic sample(input string req, input int d, input int ch, input int res);
    int e = expect_hit(d, ch, res);
    smp_valid = 1; smp_data = d[SW-1:0]; smp_chan = ch[CW-1:0]; smp_res = res[1:0];
    @(negedge clk);
    smp_valid = 0;
    check(req, int'(flag), e);
    check("R8", int'(irq), e & m_ie);
    clear_flag();
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, disabled watchdog ignores a sample above a zero bound
    check("R1", int'(flag), 0);
    check("R1", int'(irq), 0);
    sample("R1", 200, 0, 0);

    // R2 R4 R9: full sweep, all channels, each resolution
    for (int r = 0; r < 4; r++) begin
      configure(1, 0, 0, 40, 9, 1);
      for (int d = 0; d < 256; d++) sample(r == 0 ? "R2" : "R9", d, d % 4, r);
    end
    // R2: degenerate window lo == hi
    configure(1, 0, 0, 77, 77, 0);
    for (int d = 70; d < 85; d++) sample("R2", d, 3, 0);
    // R4: every channel checked
    for (int c = 0; c < 4; c++) sample("R4", 5, c, 0);

    // R3: single channel filter against each channel
    for (int k = 0; k < 4; k++) begin
      configure(1, 1, k, 100, 50, 1);
      for (int c = 0; c < 4; c++) begin
        sample("R3", 10, c, 0);
        sample("R3", 60, c, 0);
        sample("R3", 250, c, 0);
      end
    end

    // R5: sticky through in-window samples and disable
    configure(1, 0, 0, 100, 50, 1);
    smp_valid = 1; smp_data = 200; @(negedge clk);
    smp_data = 70; repeat (3) @(negedge clk);
    smp_valid = 0;
    check("R5", int'(flag), 1);
    configure(0, 0, 0, 100, 50, 1);
    check("R5", int'(flag), 1);
    // R6: write of 0 does not clear
    stat_wr = 1; stat_clr = 0; @(negedge clk); stat_wr = 0;
    check("R6", int'(flag), 1);
    // R8: interrupt masked while flag still set
    configure(0, 0, 0, 100, 50, 0);
    check("R8", int'(irq), 0);
    check("R8", int'(flag), 1);
    configure(0, 0, 0, 100, 50, 1);
    check("R8", int'(irq), 1);
    // R6: write of 1 clears
    clear_flag();
    check("R6", int'(flag), 0);
    check("R6", int'(irq), 0);

    // R7: set and clear in the same cycle
    configure(1, 0, 0, 100, 50, 1);
    smp_valid = 1; smp_data = 3; stat_wr = 1; stat_clr = 1;
    @(negedge clk);
    smp_valid = 0; stat_wr = 0; stat_clr = 0;
    check("R7", int'(flag), 1);
    clear_flag();

    // R10: sample in the write cycle uses old settings, next cycle new ones
    cfg_wr = 1; cfg_en = 1; cfg_single = 0; cfg_hi = 255; cfg_lo = 0; cfg_irq_en = 1;
    smp_valid = 1; smp_data = 3;
    @(negedge clk);
    cfg_wr = 0;
    check("R10", int'(flag), 1);
    clear_flag();
    smp_valid = 1; smp_data = 3;
    @(negedge clk);
    smp_valid = 0;
    check("R10", int'(flag), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule